// File: doc/BRIEF.md
# Intensity Centroid Orientation Unit

This block gives the dominant direction of a candidate corner. A square grey-level patch centred on the corner is streamed in raster order, one 8-bit pixel per valid cycle. A start flag marks the first pixel and a last flag marks the final one. While the pixels arrive, the unit sums the two first-order intensity moments over a disc around the patch centre. The vector formed by these two moments points from the centre towards the intensity centroid.

Once the last pixel has been taken in, the direction of that vector is quantised into one of 32 equal angular sectors. No divider, arctangent or square root is used. The unit folds the vector into the first quadrant and compares it against the fixed sector boundary directions with sign tests on cross products. The sector index is presented together with the sine and cosine of the sector's start angle in signed fixed point, so a downstream sampling stage can rotate its test pattern directly.

Top module: `intensity_orient_unit`

## Requirements
- R1: The pixel accepted with the start flag sits at column 0, row 0. Each further accepted pixel moves one column right, and after column 30 it wraps to column 0 of the next row. Coordinates are x = column − 15 and y = row − 15. Cycles with `pix_valid` low are ignored whatever the data and flags hold.
- R2: Only pixels with x² + y² ≤ 225 add to the moments. This includes pixels exactly on the radius-15 circle. Pixels outside the circle have no effect on the result.
- R3: The moment sums never overflow, even when every pixel of a half or quarter disc is 255.
- R4: `ang_bin` equals floor(θ / 11.25°), where θ is the angle in [0°, 360°) of the vector (Σx·I, Σy·I). θ is measured from +x towards +y, and all four quadrants are resolved.
- R5: Directions exactly on a sector boundary fall into the sector that starts there. +x gives 0, 45° gives 4, +y gives 8, 135° gives 12, −x gives 16, 225° gives 20 and −y gives 24.
- R6: When both moment sums are zero, the result is bin 0, sine 0 and cosine 16384.
- R7: `sin_q14` and `cos_q14` equal round(16384·sin(b·11.25°)) and round(16384·cos(b·11.25°)) for the reported bin b. Both are 16-bit two's complement values in which 16384 stands for 1.0.
- R8: `res_valid` is a one-cycle pulse in the third cycle after the cycle that carries the last pixel. Between pulses the bin, sine and cosine hold their values.
- R9: A new patch may start in the cycle right after the pulse. The start flag discards all earlier sums.
- R10: During and after reset, until the first result, `res_valid` is 0, the bin is 0, the sine is 0 and the cosine is 16384.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | Pixel present on this cycle |
| pix_sop | input | 1 | First pixel of a patch |
| pix_eop | input | 1 | Last pixel of a patch |
| pix_data | input | 8 | Grey level of the pixel |
| res_valid | output | 1 | Result pulse |
| ang_bin | output | 5 | Orientation sector, 0 to 31 |
| sin_q14 | output | 16 | Sine of the sector start angle, signed Q1.14 |
| cos_q14 | output | 16 | Cosine of the sector start angle, signed Q1.14 |

## Verification
Single bright pixels placed at chosen offsets test the fold in every quadrant, including the wrap from the last sector back to 0. Pixels on the axes and diagonals show whether boundary directions land in the right sector. A uniform patch tests the zero-moment default. Combinations of a pixel on the radius with pixels just outside it show whether the disc test includes and excludes the right pixels. Horizontal, vertical and diagonal intensity ramps confirm the raster-to-coordinate mapping. Idle gaps inside a patch, full-scale half-disc patches and a patch started right after a pulse test the framing, the headroom of the sums and the clearing of old sums.

// File: rtl/orient_pkg.sv
package orient_pkg;

    localparam int TRIG_W    = 16;
    localparam int TRIG_ONE  = 16384;
    localparam int SUB_BITS  = 3;
    localparam int SUB_STEPS = 1 << SUB_BITS;
    localparam int QUAD_BITS = 2;
    localparam int BIN_W     = SUB_BITS + QUAD_BITS;

    typedef struct packed {
        logic signed [TRIG_W-1:0] s;
        logic signed [TRIG_W-1:0] c;
    } trig_pair_t;

    // sin(k * 90deg / SUB_STEPS) in Q1.14, k = 0 .. SUB_STEPS
    function automatic logic [TRIG_W-1:0] quarter_sin(input int k);
        logic [TRIG_W-1:0] v;
        case (k)
            0:       v = 16'd0;
            1:       v = 16'd3196;
            2:       v = 16'd6270;
            3:       v = 16'd9102;
            4:       v = 16'd11585;
            5:       v = 16'd13623;
            6:       v = 16'd15137;
            7:       v = 16'd16069;
            default: v = 16'd16384;
        endcase
        return v;
    endfunction

    // sine and cosine of a sector start angle, built by quadrant symmetry
    function automatic trig_pair_t bin_trig(input logic [BIN_W-1:0] b);
        trig_pair_t r;
        logic signed [TRIG_W-1:0] near_v;
        logic signed [TRIG_W-1:0] far_v;
        near_v = $signed(quarter_sin(int'(b[SUB_BITS-1:0])));
        far_v  = $signed(quarter_sin(SUB_STEPS - int'(b[SUB_BITS-1:0])));
        case (b[BIN_W-1:SUB_BITS])
            2'd0:    begin r.s = near_v;  r.c = far_v;   end
            2'd1:    begin r.s = far_v;   r.c = -near_v; end
            2'd2:    begin r.s = -near_v; r.c = -far_v;  end
            default: begin r.s = -far_v;  r.c = near_v;  end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/orient_moment_acc.sv
module orient_moment_acc #(
    parameter int PATCH  = 31,
    parameter int RADIUS = 15,
    parameter int PIX_W  = 8,
    parameter int ACC_W  = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pix_valid,
    input  logic                    pix_sop,
    input  logic                    pix_eop,
    input  logic [PIX_W-1:0]        pix_data,
    output logic signed [ACC_W-1:0] sum_x,
    output logic signed [ACC_W-1:0] sum_y,
    output logic                    sums_done
);

    localparam int CNT_W   = $clog2(PATCH);
    localparam int COORD_W = CNT_W + 1;
    localparam int SQ_W    = 2 * COORD_W + 1;
    localparam int CENTER  = PATCH / 2;
    localparam int RAD_SQ  = RADIUS * RADIUS;

    typedef struct packed {
        logic [CNT_W-1:0]        col;
        logic [CNT_W-1:0]        row;
        logic signed [ACC_W-1:0] mx;
        logic signed [ACC_W-1:0] my;
        logic                    done;
    } acc_state_t;

    acc_state_t st_d, st_q;

    logic [CNT_W-1:0]          col_now, row_now;
    logic signed [COORD_W-1:0] x_rel, y_rel;
    logic signed [SQ_W-1:0]    rad2;
    logic                      in_disc;
    logic signed [ACC_W-1:0]   pix_s, x_ext, y_ext;
    logic signed [ACC_W-1:0]   base_x, base_y;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;

        col_now = pix_sop ? '0 : st_q.col;
        row_now = pix_sop ? '0 : st_q.row;
        base_x  = pix_sop ? '0 : st_q.mx;
        base_y  = pix_sop ? '0 : st_q.my;

        x_rel   = $signed({1'b0, col_now}) - COORD_W'(CENTER);
        y_rel   = $signed({1'b0, row_now}) - COORD_W'(CENTER);
        rad2    = SQ_W'(x_rel) * SQ_W'(x_rel) + SQ_W'(y_rel) * SQ_W'(y_rel);
        in_disc = (rad2 <= SQ_W'(RAD_SQ));

        pix_s = ACC_W'($signed({1'b0, pix_data}));
        x_ext = ACC_W'(x_rel);
        y_ext = ACC_W'(y_rel);

        if (pix_valid) begin
            st_d.mx   = in_disc ? base_x + x_ext * pix_s : base_x;
            st_d.my   = in_disc ? base_y + y_ext * pix_s : base_y;
            st_d.done = pix_eop;
            if (col_now == CNT_W'(PATCH - 1)) begin
                st_d.col = '0;
                st_d.row = row_now + 1'b1;
            end else begin
                st_d.col = col_now + 1'b1;
                st_d.row = row_now;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum_x     = st_q.mx;
    assign sum_y     = st_q.my;
    assign sums_done = st_q.done;

endmodule

// File: rtl/orient_quadrant_fold.sv
module orient_quadrant_fold #(
    parameter int ACC_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [ACC_W-1:0] vec_x,
    input  logic signed [ACC_W-1:0] vec_y,
    output logic                    out_valid,
    output logic [1:0]              quad,
    output logic                    is_zero,
    output logic [ACC_W-1:0]        fold_u,
    output logic [ACC_W-1:0]        fold_w
);

    typedef struct packed {
        logic             valid;
        logic [1:0]       quad;
        logic             zero;
        logic [ACC_W-1:0] u;
        logic [ACC_W-1:0] w;
    } fold_state_t;

    fold_state_t st_d, st_q;

    logic x_pos, x_neg, y_pos, y_neg;

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;

        x_pos = !vec_x[ACC_W-1] && (vec_x != '0);
        x_neg = vec_x[ACC_W-1];
        y_pos = !vec_y[ACC_W-1] && (vec_y != '0);
        y_neg = vec_y[ACC_W-1];

        if (in_valid) begin
            st_d.zero = (vec_x == '0) && (vec_y == '0);
            if (x_pos && !y_neg) begin
                st_d.quad = 2'd0;
                st_d.u    = vec_x;
                st_d.w    = vec_y;
            end else if (!x_pos && y_pos) begin
                st_d.quad = 2'd1;
                st_d.u    = vec_y;
                st_d.w    = -vec_x;
            end else if (x_neg && !y_pos) begin
                st_d.quad = 2'd2;
                st_d.u    = -vec_x;
                st_d.w    = -vec_y;
            end else if (y_neg) begin
                st_d.quad = 2'd3;
                st_d.u    = -vec_y;
                st_d.w    = vec_x;
            end else begin
                st_d.quad = 2'd0;
                st_d.u    = '0;
                st_d.w    = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign quad      = st_q.quad;
    assign is_zero   = st_q.zero;
    assign fold_u    = st_q.u;
    assign fold_w    = st_q.w;

endmodule

// File: rtl/orient_bin_search.sv
module orient_bin_search
    import orient_pkg::*;
#(
    parameter int ACC_W = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [1:0]               quad,
    input  logic                     is_zero,
    input  logic [ACC_W-1:0]         fold_u,
    input  logic [ACC_W-1:0]         fold_w,
    output logic                     res_valid,
    output logic [BIN_W-1:0]         res_bin,
    output logic signed [TRIG_W-1:0] res_sin,
    output logic signed [TRIG_W-1:0] res_cos
);

    localparam int PROD_W = ACC_W + TRIG_W;

    typedef struct packed {
        logic                     valid;
        logic [BIN_W-1:0]         bin;
        logic signed [TRIG_W-1:0] s;
        logic signed [TRIG_W-1:0] c;
    } bin_state_t;

    bin_state_t st_d, st_q;

    // one flag per interior sector boundary of the folded quadrant
    logic [SUB_STEPS-2:0] past_edge;

    for (genvar k = 1; k < SUB_STEPS; k++) begin : g_edge
        localparam logic [TRIG_W-1:0] EDGE_COS = quarter_sin(SUB_STEPS - k);
        localparam logic [TRIG_W-1:0] EDGE_SIN = quarter_sin(k);
        assign past_edge[k-1] =
            (PROD_W'(EDGE_COS) * PROD_W'(fold_w)) >= (PROD_W'(EDGE_SIN) * PROD_W'(fold_u));
    end

    logic [SUB_BITS-1:0] sub_idx;
    logic [BIN_W-1:0]    bin_now;
    trig_pair_t          trig_now;

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        sub_idx    = SUB_BITS'($countones(past_edge));
        bin_now    = is_zero ? '0 : {quad, sub_idx};
        trig_now   = bin_trig(bin_now);
        if (in_valid) begin
            st_d.bin = bin_now;
            st_d.s   = trig_now.s;
            st_d.c   = trig_now.c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.valid <= 1'b0;
            st_q.bin   <= '0;
            st_q.s     <= '0;
            st_q.c     <= TRIG_W'(TRIG_ONE);
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.valid;
    assign res_bin   = st_q.bin;
    assign res_sin   = st_q.s;
    assign res_cos   = st_q.c;

endmodule

// File: rtl/intensity_orient_unit.sv
module intensity_orient_unit #(
    parameter int PATCH  = 31,
    parameter int RADIUS = 15,
    parameter int PIX_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pix_valid,
    input  logic                pix_sop,
    input  logic                pix_eop,
    input  logic [PIX_W-1:0]    pix_data,
    output logic                res_valid,
    output logic [4:0]          ang_bin,
    output logic signed [15:0]  sin_q14,
    output logic signed [15:0]  cos_q14
);

    localparam int ACC_W = $clog2(RADIUS * ((1 << PIX_W) - 1) * PATCH * PATCH) + 2;

    logic signed [ACC_W-1:0] sum_x, sum_y;
    logic                    sums_done;
    logic                    fold_valid, fold_zero;
    logic [1:0]              fold_quad;
    logic [ACC_W-1:0]        fold_u, fold_w;

    orient_moment_acc #(
        .PATCH(PATCH), .RADIUS(RADIUS), .PIX_W(PIX_W), .ACC_W(ACC_W)
    ) i_acc (
        .clk(clk), .rst_n(rst_n),
        .pix_valid(pix_valid), .pix_sop(pix_sop), .pix_eop(pix_eop), .pix_data(pix_data),
        .sum_x(sum_x), .sum_y(sum_y), .sums_done(sums_done)
    );

    orient_quadrant_fold #(.ACC_W(ACC_W)) i_fold (
        .clk(clk), .rst_n(rst_n),
        .in_valid(sums_done), .vec_x(sum_x), .vec_y(sum_y),
        .out_valid(fold_valid), .quad(fold_quad), .is_zero(fold_zero),
        .fold_u(fold_u), .fold_w(fold_w)
    );

    orient_bin_search #(.ACC_W(ACC_W)) i_search (
        .clk(clk), .rst_n(rst_n),
        .in_valid(fold_valid), .quad(fold_quad), .is_zero(fold_zero),
        .fold_u(fold_u), .fold_w(fold_w),
        .res_valid(res_valid), .res_bin(ang_bin), .res_sin(sin_q14), .res_cos(cos_q14)
    );

endmodule

// File: rtl/orient_unit_checker.sv
module orient_unit_checker (
    input logic               clk,
    input logic               rst_n,
    input logic               pix_valid,
    input logic               pix_eop,
    input logic               res_valid,
    input logic [4:0]         ang_bin,
    input logic signed [15:0] sin_q14,
    input logic signed [15:0] cos_q14
);

    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(pix_valid && pix_eop, 3));

    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ($stable(ang_bin) && $stable(sin_q14) && $stable(cos_q14)));

    a_r7_unit_range: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (sin_q14 >= -16'sd16384 && sin_q14 <= 16'sd16384 &&
                       cos_q14 >= -16'sd16384 && cos_q14 <= 16'sd16384));

    a_r7_quadrant_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && ang_bin[4:3] == 2'd0) |-> (sin_q14 >= 16'sd0 && cos_q14 > 16'sd0));

    a_r7_third_quadrant: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && ang_bin[4:3] == 2'd2) |-> (sin_q14 <= 16'sd0 && cos_q14 < 16'sd0));

endmodule

bind intensity_orient_unit orient_unit_checker i_orient_chk (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_eop(pix_eop),
    .res_valid(res_valid), .ang_bin(ang_bin), .sin_q14(sin_q14), .cos_q14(cos_q14)
);

// File: tb/test_intensity_orient_unit.sv
module test_intensity_orient_unit;

    localparam int  CLK_PERIOD = 10;
    localparam int  PATCH      = 31;
    localparam int  HALF       = 15;
    localparam int  NPIX       = PATCH * PATCH;
    localparam real PI         = 3.14159265358979;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_valid = 1'b0, pix_sop = 1'b0, pix_eop = 1'b0;
    logic [7:0] pix_data = 8'h00;
    logic res_valid;
    logic [4:0] ang_bin;
    logic signed [15:0] sin_q14, cos_q14;

    int pat [NPIX];
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    int got_lat, got_bin, got_sin, got_cos, pre_valid;

    always #(CLK_PERIOD / 2) clk = ~clk;

    intensity_orient_unit i_intensity_orient_unit (
        .clk(clk), .rst_n(rst_n),
        .pix_valid(pix_valid), .pix_sop(pix_sop), .pix_eop(pix_eop), .pix_data(pix_data),
        .res_valid(res_valid), .ang_bin(ang_bin), .sin_q14(sin_q14), .cos_q14(cos_q14)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int rnd(input real r);
        if (r >= 0.0) return int'($floor(r + 0.5));
        return -int'($floor(-r + 0.5));
    endfunction

    task automatic clear_pat(input int v);
        for (int i = 0; i < NPIX; i++) pat[i] = v;
    endtask

    task automatic set_pt(input int x, input int y, input int v);
        pat[(y + HALF) * PATCH + (x + HALF)] = v;
    endtask

    function automatic void compute_ref(output int b, output int s, output int c);
        longint mx, my;
        real ang;
        mx = 0;
        my = 0;
        for (int i = 0; i < NPIX; i++) begin
            int x, y;
            x = (i % PATCH) - HALF;
            y = (i / PATCH) - HALF;
            if (x * x + y * y <= HALF * HALF) begin
                mx += longint'(x * pat[i]);
                my += longint'(y * pat[i]);
            end
        end
        if (mx == 0 && my == 0) begin
            b = 0;
        end else begin
            ang = $atan2(real'(my), real'(mx)) * 180.0 / PI;
            if (ang < 0.0) ang += 360.0;
            b = int'($floor(ang / 11.25 + 1e-9));
            if (b > 31) b = 0;
        end
        s = rnd(16384.0 * $sin(real'(b) * PI / 16.0));
        c = rnd(16384.0 * $cos(real'(b) * PI / 16.0));
    endfunction

    task automatic run_patch(input int gap);
        for (int i = 0; i < NPIX; i++) begin
            @(negedge clk);
            if (i == 0) pre_valid = int'(res_valid);
            if (gap > 0 && i > 0 && (i % gap) == 0) begin
                pix_valid = 1'b0;
                pix_sop   = 1'b1;
                pix_eop   = 1'b1;
                pix_data  = 8'hFF;
                @(negedge clk);
            end
            pix_valid = 1'b1;
            pix_sop   = (i == 0);
            pix_eop   = (i == NPIX - 1);
            pix_data  = 8'(pat[i]);
        end
        @(negedge clk);
        pix_valid = 1'b0;
        pix_sop   = 1'b0;
        pix_eop   = 1'b0;
        pix_data  = 8'hA5;
        got_lat = 1;
        while (!res_valid && got_lat < 12) begin
            @(negedge clk);
            got_lat++;
        end
        got_bin = int'(ang_bin);
        got_sin = int'(sin_q14);
        got_cos = int'(cos_q14);
    endtask

    task automatic run_and_check(input string req, input string name, input int gap);
        int eb, es, ec;
        compute_ref(eb, es, ec);
        run_patch(gap);
        check("R8", {name, " pulse ended before next patch"}, pre_valid, 0);
        check("R8", {name, " latency"}, got_lat, 3);
        check(req, {name, " bin"}, got_bin, eb);
        check("R7", {name, " sine"}, got_sin, es);
        check("R7", {name, " cosine"}, got_cos, ec);
    endtask

    // R10: reset values
    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R10", "valid in reset", int'(res_valid), 0);
        check("R10", "bin in reset", int'(ang_bin), 0);
        check("R10", "sine in reset", int'(sin_q14), 0);
        check("R10", "cosine in reset", int'(cos_q14), 16384);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R10", "valid after reset", int'(res_valid), 0);
        check("R10", "cosine after reset", int'(cos_q14), 16384);
    endtask

    // R6: zero moments
    task automatic t_zero();
        clear_pat(100);
        run_and_check("R6", "uniform patch", 0);
        check("R6", "uniform bin literal", got_bin, 0);
        check("R6", "uniform cosine literal", got_cos, 16384);
    endtask

    // R4: single bright pixels in all quadrants and the wrap sector
    task automatic t_points();
        clear_pat(0); set_pt(10, 3, 200);   run_and_check("R4", "point q0", 0);
        check("R4", "point (10,3) literal", got_bin, 1);
        clear_pat(0); set_pt(-4, 9, 90);    run_and_check("R4", "point q1", 0);
        check("R4", "point (-4,9) literal", got_bin, 10);
        clear_pat(0); set_pt(-9, -5, 77);   run_and_check("R4", "point q2", 0);
        clear_pat(0); set_pt(3, -12, 255);  run_and_check("R4", "point q3", 0);
        clear_pat(0); set_pt(10, -1, 60);   run_and_check("R4", "point wrap", 0);
        check("R4", "point (10,-1) literal", got_bin, 31);
        clear_pat(0); set_pt(2, 13, 1);     run_and_check("R4", "point near +y", 0);
    endtask

    // R5: boundary directions
    task automatic t_axes();
        clear_pat(0); set_pt(12, 0, 50);   run_and_check("R5", "+x axis", 0);
        clear_pat(0); set_pt(0, 12, 50);   run_and_check("R5", "+y axis", 0);
        check("R5", "+y literal", got_bin, 8);
        clear_pat(0); set_pt(-12, 0, 50);  run_and_check("R5", "-x axis", 0);
        check("R5", "-x literal", got_bin, 16);
        clear_pat(0); set_pt(0, -12, 50);  run_and_check("R5", "-y axis", 0);
        check("R5", "-y literal", got_bin, 24);
        clear_pat(0); set_pt(7, 7, 50);    run_and_check("R5", "45 deg", 0);
        check("R5", "45 deg literal", got_bin, 4);
        clear_pat(0); set_pt(-6, 6, 50);   run_and_check("R5", "135 deg", 0);
        check("R5", "135 deg literal", got_bin, 12);
    endtask

    // R2: disc membership
    task automatic t_disc();
        clear_pat(0); set_pt(15, 15, 255); set_pt(-5, 8, 50);
        run_and_check("R2", "corner outside disc", 0);
        check("R2", "corner ignored literal", got_bin, 10);
        clear_pat(0); set_pt(-15, 0, 200); set_pt(11, 11, 200);
        run_and_check("R2", "on-radius kept, outside dropped", 0);
        check("R2", "on-radius literal", got_bin, 16);
    endtask

    // R1: raster mapping and idle cycles
    task automatic t_raster();
        for (int i = 0; i < NPIX; i++) pat[i] = 8 * (i % PATCH);
        run_and_check("R1", "ramp along x", 0);
        for (int i = 0; i < NPIX; i++) pat[i] = 8 * (PATCH - 1 - i / PATCH);
        run_and_check("R1", "ramp falling in y", 0);
        check("R1", "falling y literal", got_bin, 24);
        for (int i = 0; i < NPIX; i++) pat[i] = 4 * ((i % PATCH) + (i / PATCH));
        run_and_check("R1", "diagonal ramp", 0);
        clear_pat(0); set_pt(-9, -5, 77);
        run_and_check("R1", "point with idle gaps", 7);
    endtask

    // R3: full-scale sums
    task automatic t_wide();
        for (int i = 0; i < NPIX; i++) pat[i] = ((i % PATCH) > HALF) ? 255 : 0;
        run_and_check("R3", "right half at 255", 0);
        for (int i = 0; i < NPIX; i++)
            pat[i] = ((i % PATCH) < HALF && (i / PATCH) < HALF) ? 255 : 0;
        run_and_check("R3", "lower-left quarter at 255", 0);
        check("R3", "quarter literal", got_bin, 20);
    endtask

    // R9: back-to-back patches
    task automatic t_back_to_back();
        clear_pat(0); set_pt(10, 3, 200);
        run_and_check("R9", "first of pair", 0);
        clear_pat(0); set_pt(-9, -5, 30);
        run_and_check("R9", "second of pair", 0);
        check("R9", "second clears old sums", got_bin, 18);
    endtask

    initial begin
        t_reset();
        t_zero();
        t_points();
        t_axes();
        t_disc();
        t_raster();
        t_wide();
        t_back_to_back();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule